// File: doc/BRIEF.md
# Two-Pass Integer Multiply-Accumulate Unit

This block multiplies two 32-bit integers on a 32-by-16 multiplier array and either stores the 64-bit product in a HI/LO register pair, adds it to that pair, subtracts it from that pair, or returns its low word as a general-register result. The first operand (rs) always occupies the 32-bit side of the array. The second operand (rt) is examined on issue. If rt can be represented in 16 bits, the product is formed in one pass. Otherwise the array is used a second time for the upper half of rt, and that partial product is shifted left by 16 and added to the first.

An issuing pipeline offers one operation per clock on the issue port. It holds an operation in place for as long as `stall` is high. Single-pass operations may follow one another on every clock. A two-pass operation occupies the array for the next clock as well, and any issue offered in that clock is held back. HI/LO is always visible on the read outputs and can be loaded from the write port. Register-destination results appear as a one-clock pulse on `res_valid`.

Top module: `mac_pass_unit`

## Requirements
- R1: During and after reset, `acc_hi`, `acc_lo` and `res_data` are zero, and `res_valid` and `stall` are low.
- R2: The pass count depends only on rt. With `iss_signed`=0 an operation is single-pass exactly when rt[31:16] is zero. With `iss_signed`=1 it is single-pass exactly when rt[31:15] are all equal. The value of rs never changes the pass count.
- R3: A single-pass operation with `iss_op`=00 (plain multiply) accepted at clock edge k shows its 64-bit product on {`acc_hi`,`acc_lo`} after edge k+1. Single-pass operations can be accepted on consecutive edges.
- R4: A two-pass operation accepted at edge k raises `stall` for exactly the following clock. An issue offered in that clock is not accepted and must be held. The 64-bit result reaches HI/LO after edge k+2.
- R5: `iss_op`=01 (multiply-add) replaces {HI,LO} with {HI,LO} plus the product, modulo 2^64.
- R6: `iss_op`=10 (multiply-subtract) replaces {HI,LO} with {HI,LO} minus the product, modulo 2^64.
- R7: `iss_op`=11 (register multiply) pulses `res_valid` for one clock, with the low 32 bits of the product on `res_data`. The pulse follows edge k+2 for a single-pass operand and edge k+3 for a two-pass operand. HI/LO is not changed.
- R8: With `iss_signed`=1 both operands are treated as two's complement. With `iss_signed`=0 both are treated as unsigned.
- R9: When `hl_we` is high at an edge, {`hl_wr_hi`,`hl_wr_lo`} is loaded into HI/LO. If a HI/LO-writing operation completes at that same edge, the operation's result is kept instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An operation is offered |
| iss_op | input | 2 | 00 multiply, 01 multiply-add, 10 multiply-subtract, 11 register multiply |
| iss_signed | input | 1 | 1 for two's complement operands |
| iss_a | input | 32 | First operand rs (32-bit side of the array) |
| iss_b | input | 32 | Second operand rt (inspected for pass count) |
| stall | output | 1 | Offered operation is not taken this clock |
| res_valid | output | 1 | Register multiply result is valid |
| res_data | output | 32 | Low word of the register multiply product |
| acc_hi | output | 32 | Upper accumulator word HI |
| acc_lo | output | 32 | Lower accumulator word LO |
| hl_we | input | 1 | Load HI/LO from the write port |
| hl_wr_hi | input | 32 | Value for HI |
| hl_wr_lo | input | 32 | Value for LO |

## Verification
For an operation accepted at edge k, HI/LO is due after edge k+1 for a single pass and after k+2 for two passes. `res_valid` is due one edge later than HI/LO would be. `stall` is due in the single clock after a two-pass acceptance. The bench drives on the falling edge and samples one falling edge at a time. On every intermediate falling edge it checks that HI/LO still holds the old value, or that `res_valid` is still low. It then checks the new value on the exact falling edge where the result is due. As a result, an operand routed to the wrong pass count shows up as an early or late result.

// File: rtl/mac_pass_unit.sv
module mac_pass_unit #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [1:0]    iss_op,
  input  logic          iss_signed,
  input  logic [DW-1:0] iss_a,
  input  logic [DW-1:0] iss_b,
  output logic          stall,
  output logic          res_valid,
  output logic [DW-1:0] res_data,
  output logic [DW-1:0] acc_hi,
  output logic [DW-1:0] acc_lo,
  input  logic          hl_we,
  input  logic [DW-1:0] hl_wr_hi,
  input  logic [DW-1:0] hl_wr_lo
);
  localparam int HW = DW / 2;
  localparam int PW = DW + HW + 2;
  localparam int AW = 2 * DW;
  localparam logic [1:0] OP_MULT = 2'd0, OP_MADD = 2'd1, OP_MSUB = 2'd2, OP_MUL = 2'd3;

  logic                 accept, b_short, done;
  logic signed [DW:0]   a_ext;
  logic signed [HW:0]   b_lo_ext, b_hi_ext;
  logic signed [PW-1:0] pp_first, pp_second;
  logic [AW-1:0]        first_ext, second_sh;

  logic                 x_valid, x_two;
  logic [1:0]           x_op;
  logic signed [DW:0]   x_a;
  logic signed [HW:0]   x_bh;
  logic [AW-1:0]        x_prod;

  logic                 m_valid;
  logic [DW-1:0]        m_data;
  logic [AW-1:0]        hilo;

  assign stall  = x_valid & x_two;
  assign accept = iss_valid & ~stall;
  assign done   = x_valid & ~x_two;

  assign b_short = iss_signed ? (&iss_b[DW-1:HW-1] | ~|iss_b[DW-1:HW-1])
                              : ~|iss_b[DW-1:HW];

  assign a_ext    = {iss_signed & iss_a[DW-1], iss_a};
  assign b_lo_ext = {iss_signed & b_short & iss_b[HW-1], iss_b[HW-1:0]};
  assign b_hi_ext = {iss_signed & iss_b[DW-1], iss_b[DW-1:HW]};

  assign pp_first  = a_ext * b_lo_ext;
  assign pp_second = x_a * x_bh;
  assign first_ext = {{(AW-PW){pp_first[PW-1]}}, pp_first};
  assign second_sh = {{(AW-PW){pp_second[PW-1]}}, pp_second} << HW;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_valid <= 1'b0;
      x_two   <= 1'b0;
      x_op    <= OP_MULT;
      x_a     <= '0;
      x_bh    <= '0;
      x_prod  <= '0;
    end else if (stall) begin
      x_two  <= 1'b0;
      x_prod <= x_prod + second_sh;
    end else begin
      x_valid <= accept;
      x_two   <= accept & ~b_short;
      x_op    <= iss_op;
      x_a     <= a_ext;
      x_bh    <= b_hi_ext;
      x_prod  <= first_ext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hilo      <= '0;
      m_valid   <= 1'b0;
      m_data    <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      if (done && x_op != OP_MUL) begin
        case (x_op)
          OP_MADD: hilo <= hilo + x_prod;
          OP_MSUB: hilo <= hilo - x_prod;
          default: hilo <= x_prod;
        endcase
      end else if (hl_we) begin
        hilo <= {hl_wr_hi, hl_wr_lo};
      end
      m_valid   <= done && x_op == OP_MUL;
      m_data    <= x_prod[DW-1:0];
      res_valid <= m_valid;
      res_data  <= m_data;
    end
  end

  assign acc_hi = hilo[AW-1:DW];
  assign acc_lo = hilo[DW-1:0];
endmodule

module mac_pass_unit_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iss_valid,
  input logic          stall,
  input logic          res_valid,
  input logic [DW-1:0] acc_hi,
  input logic [DW-1:0] acc_lo,
  input logic          hl_we
);
  a_r4_stall_single: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  a_r4_stall_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> ($past(iss_valid) && !$past(stall)));

  a_r7_res_from_issue: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($past(iss_valid, 3) || $past(iss_valid, 4)));

  a_r9_hilo_source: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({acc_hi, acc_lo}) |-> ($past(hl_we) || $past(iss_valid, 2) || $past(iss_valid, 3)));
endmodule

bind mac_pass_unit mac_pass_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .stall(stall),
  .res_valid(res_valid), .acc_hi(acc_hi), .acc_lo(acc_lo), .hl_we(hl_we)
);

// File: tb/mac_pass_unit_bench.sv
module mac_pass_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic [1:0]  iss_op = 2'd0;
  logic        iss_signed = 1'b0;
  logic [31:0] iss_a = '0, iss_b = '0;
  logic        stall, res_valid;
  logic [31:0] res_data, acc_hi, acc_lo;
  logic        hl_we = 1'b0;
  logic [31:0] hl_wr_hi = '0, hl_wr_lo = '0;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [63:0] ref_hl = '0;

  always #5 clk = ~clk;

  mac_pass_unit u_mac_pass_unit (.*);

  function automatic logic [63:0] product(logic sgn, logic [31:0] a, logic [31:0] b);
    if (sgn) return $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
    return {32'b0, a} * {32'b0, b};
  endfunction

  function automatic bit fits16(logic sgn, logic [31:0] b);
    if (sgn) return (b[31:15] == 17'h0) || (b[31:15] == 17'h1ffff);
    return b[31:16] == 16'h0;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(logic [1:0] op, logic sgn, logic [31:0] a, logic [31:0] b, string tag);
    logic [63:0] p = product(sgn, a, b);
    logic [63:0] old = ref_hl;
    int lat = fits16(sgn, b) ? 1 : 2;
    @(negedge clk);
    iss_valid = 1'b1; iss_op = op; iss_signed = sgn; iss_a = a; iss_b = b;
    @(negedge clk);
    iss_valid = 1'b0;
    case (op)
      2'd0: ref_hl = p;
      2'd1: ref_hl = old + p;
      2'd2: ref_hl = old - p;
      default: ref_hl = old;
    endcase
    if (op != 2'd3) begin
      for (int i = 1; i <= lat; i++) begin
        check({acc_hi, acc_lo} == old, {tag, " early"}, {acc_hi, acc_lo}, old);
        @(negedge clk);
      end
      check({acc_hi, acc_lo} == ref_hl, tag, {acc_hi, acc_lo}, ref_hl);
    end else begin
      for (int i = 1; i <= lat + 1; i++) begin
        check(!res_valid, {tag, " early"}, 64'(res_valid), 64'd0);
        @(negedge clk);
      end
      check(res_valid && res_data == p[31:0], tag, {31'd0, res_valid, res_data}, {32'd1, p[31:0]});
      check({acc_hi, acc_lo} == ref_hl, {tag, " hilo kept"}, {acc_hi, acc_lo}, ref_hl);
      @(negedge clk);
      check(!res_valid, {tag, " pulse"}, 64'(res_valid), 64'd0);
    end
  endtask

  task automatic write_hl(logic [63:0] v, string tag);
    @(negedge clk);
    hl_we = 1'b1; {hl_wr_hi, hl_wr_lo} = v;
    @(negedge clk);
    hl_we = 1'b0;
    ref_hl = v;
    check({acc_hi, acc_lo} == v, tag, {acc_hi, acc_lo}, v);
  endtask

  task automatic t_reset;
    check({acc_hi, acc_lo} == 64'd0 && !res_valid && !stall && res_data == 0,
          "R1 reset", {acc_hi, acc_lo}, 64'd0);
  endtask

  task automatic t_sizing;
    run_op(2'd0, 1'b0, 32'h1234_5678, 32'h0000_abcd, "R3 unsigned short");
    run_op(2'd0, 1'b0, 32'hffff_ffff, 32'h0000_0003, "R2 wide rs short rt");
    run_op(2'd0, 1'b1, 32'h0000_0007, 32'h0000_8000, "R2 signed 0x8000 two pass");
    run_op(2'd0, 1'b0, 32'h0000_0005, 32'h0000_8000, "R2 unsigned 0x8000 one pass");
    run_op(2'd0, 1'b1, 32'h0001_0003, 32'hffff_8000, "R2 signed negative one pass");
    run_op(2'd0, 1'b0, 32'h0000_0009, 32'h0001_0000, "R2 unsigned 0x10000 two pass");
  endtask

  task automatic t_signedness;
    run_op(2'd0, 1'b1, 32'h8000_0000, 32'hffff_ffff, "R8 signed min times minus one");
    run_op(2'd0, 1'b0, 32'h8000_0000, 32'hffff_ffff, "R8 unsigned same bits");
    run_op(2'd0, 1'b1, 32'hffff_fffe, 32'h7fff_ffff, "R8 mixed sign long");
    run_op(2'd0, 1'b0, 32'hdead_beef, 32'hcafe_f00d, "R4 unsigned long");
  endtask

  task automatic t_accumulate;
    write_hl(64'h0000_0001_0000_0000, "R9 plain load");
    run_op(2'd1, 1'b0, 32'hffff_ffff, 32'h0000_ffff, "R5 madd short");
    run_op(2'd1, 1'b1, 32'h8765_4321, 32'h9abc_def0, "R5 madd signed long");
    write_hl(64'd0, "R9 clear");
    run_op(2'd2, 1'b0, 32'h0000_0001, 32'h0000_0001, "R6 msub wraps below zero");
    run_op(2'd2, 1'b1, 32'hffff_fff0, 32'h1234_5678, "R6 msub signed long");
  endtask

  task automatic t_regmul;
    run_op(2'd3, 1'b1, 32'hffff_fffd, 32'h0000_0011, "R7 reg mul short");
    run_op(2'd3, 1'b0, 32'h0123_4567, 32'h89ab_cdef, "R7 reg mul long");
  endtask

  task automatic t_back_to_back_short;
    logic [63:0] pa = product(1'b0, 32'h11, 32'h22);
    logic [63:0] pb = product(1'b0, 32'h1000, 32'h3);
    logic [63:0] pc = product(1'b1, 32'hffff_ff00, 32'h7);
    write_hl(64'd0, "R9 clear");
    @(negedge clk);
    iss_valid = 1'b1; iss_op = 2'd1; iss_signed = 1'b0; iss_a = 32'h11; iss_b = 32'h22;
    @(negedge clk);
    check(!stall, "R3 no stall between short ops", 64'(stall), 64'd0);
    iss_a = 32'h1000; iss_b = 32'h3;
    @(negedge clk);
    check({acc_hi, acc_lo} == pa, "R3 first of burst", {acc_hi, acc_lo}, pa);
    iss_signed = 1'b1; iss_a = 32'hffff_ff00; iss_b = 32'h7;
    @(negedge clk);
    iss_valid = 1'b0;
    check({acc_hi, acc_lo} == pa + pb, "R3 second of burst", {acc_hi, acc_lo}, pa + pb);
    @(negedge clk);
    ref_hl = pa + pb + pc;
    check({acc_hi, acc_lo} == ref_hl, "R5 burst total", {acc_hi, acc_lo}, ref_hl);
  endtask

  task automatic t_back_to_back_long;
    logic [63:0] pa = product(1'b0, 32'h8000_0001, 32'h0003_0001);
    logic [63:0] pb = product(1'b1, 32'h7fff_0000, 32'hfedc_ba98);
    @(negedge clk);
    iss_valid = 1'b1; iss_op = 2'd0; iss_signed = 1'b0; iss_a = 32'h8000_0001; iss_b = 32'h0003_0001;
    @(negedge clk);
    check(stall, "R4 stall after long", 64'(stall), 64'd1);
    iss_op = 2'd1; iss_signed = 1'b1; iss_a = 32'h7fff_0000; iss_b = 32'hfedc_ba98;
    @(negedge clk);
    check(!stall, "R4 stall lasts one clock", 64'(stall), 64'd0);
    @(negedge clk);
    iss_valid = 1'b0;
    check(stall, "R4 second long stalls again", 64'(stall), 64'd1);
    check({acc_hi, acc_lo} == pa, "R4 first long result", {acc_hi, acc_lo}, pa);
    @(negedge clk);
    check({acc_hi, acc_lo} == pa, "R4 held op not yet done", {acc_hi, acc_lo}, pa);
    @(negedge clk);
    ref_hl = pa + pb;
    check({acc_hi, acc_lo} == ref_hl, "R4 held op accumulated once", {acc_hi, acc_lo}, ref_hl);
  endtask

  task automatic t_write_collision;
    logic [63:0] p = product(1'b0, 32'h55, 32'h66);
    @(negedge clk);
    iss_valid = 1'b1; iss_op = 2'd0; iss_signed = 1'b0; iss_a = 32'h55; iss_b = 32'h66;
    @(negedge clk);
    iss_valid = 1'b0;
    hl_we = 1'b1; hl_wr_hi = 32'haaaa_aaaa; hl_wr_lo = 32'h5555_5555;
    @(negedge clk);
    hl_we = 1'b0;
    ref_hl = p;
    check({acc_hi, acc_lo} == p, "R9 completion beats write", {acc_hi, acc_lo}, p);
  endtask

  task automatic t_random;
    for (int i = 0; i < 24; i++) begin
      logic [31:0] a = $urandom;
      logic [31:0] b = $urandom;
      logic sgn = 1'($urandom);
      logic [1:0] op = 2'($urandom);
      if ($urandom % 2 == 0) b = sgn ? {{16{b[15]}}, b[15:0]} : {16'h0, b[15:0]};
      run_op(op, sgn, a, b, "R8 random mixed");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sizing();
    t_signedness();
    t_accumulate();
    t_regmul();
    t_back_to_back_short();
    t_back_to_back_long();
    t_write_collision();
    t_random();
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule